// File: doc/BRIEF.md
# Strip Pedestal Threshold Hit Finder

This block takes one multiplexed readout frame of silicon strip samples per event and finds the strips that carry signal. A frame opens with a fixed-length header, which the block skips. The strip samples follow, one per clock. Each sample is compared against a pedestal that software loads for its channel, plus a threshold that is captured when the frame starts. A fast first pass uses the raw pedestals and gives a per-strip hit bit for a serial trigger path, one clock after each sample.

While the frame streams in, the block builds an event-wide common-mode correction from two sums. The first sum adds, for every strip, the sample or the pedestal, whichever is smaller. The second sum adds all the pedestals. Each sum is divided by the strip count with an arithmetic shift, and the second result is subtracted from the first. The frame is stored in one of two banks. A second pass then rescans the stored frame against the pedestal plus the correction plus the threshold. For every strip that passes, it emits the strip number, the sample and its two neighbours. This rescan takes exactly as many cycles as there are strips, so the next frame can follow with no gap.

Receiver states: `RX_IDLE` goes to `RX_HDR` on a frame start. `RX_HDR` goes to `RX_SAMP` after the last header word. `RX_SAMP` goes back to `RX_IDLE` after the last strip. Scan states: `SC_IDLE` goes to `SC_RUN` on the last strip of a frame. `SC_RUN` goes back to `SC_IDLE` after the last strip index, unless another frame has just ended.

Top module: `strip_hit_finder`

## Requirements
- R1: After reset, `trig_valid`, `corr_valid` and `hit_valid` are low, and every pedestal reads as zero.
- R2: A `frm_start` pulse in `RX_IDLE` marks header word 0. The next HDR-1 words are also header words and are ignored. The NCH words after the header are strips 0 to NCH-1 in order. A `frm_start` that arrives while a frame is being received is ignored. `trig_valid` is high exactly in the cycle after each strip word and at no other time.
- R3: `trig_hit` is 1 when the sample is strictly greater than its stored pedestal plus the threshold. A sample equal to that sum is not a hit. The threshold is the value of `thr_level` in the `frm_start` cycle.
- R4: In the cycle after the last strip word, `corr_valid` pulses for one cycle. At the same time `corr_value` carries floor(S1/NCH) − floor(S2/NCH) as a signed value. S1 is the sum over all strips of min(sample, pedestal), and S2 is the sum of all pedestals.
- R5: The second pass flags strip i when its sample is strictly greater than pedestal + `corr_value` + threshold, evaluated as signed numbers.
- R6: Second-pass records appear in ascending strip order. The record for strip i is presented in cycle L+2+i, where L is the cycle of the last strip word. `hit_valid` is low for strips that do not pass.
- R7: A record carries the strip number, the centre sample, the left sample (strip i−1) and the right sample (strip i+1). `hit_nb_ok` bit 0 is 1 when the left neighbour exists, and bit 1 is 1 when the right neighbour exists. A missing neighbour reads as zero.
- R8: A pedestal write takes effect only when the receiver is in `RX_IDLE` and the scan is in `SC_IDLE`. At any other time the write is ignored.
- R9: A frame whose `frm_start` falls in the cycle right after the previous frame's last strip word is processed in full. The results of both frames are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Marks header word 0 of a frame |
| adc_data | input | DW | Header or strip sample, one per clock |
| thr_level | input | DW | Hit threshold, captured at frame start |
| ped_we | input | 1 | Pedestal write strobe |
| ped_addr | input | $clog2(NCH) | Pedestal write channel |
| ped_wdata | input | DW | Pedestal write value |
| trig_valid | output | 1 | Fast-pass result valid |
| trig_hit | output | 1 | Fast-pass hit bit, strips in order |
| corr_valid | output | 1 | Correction value valid |
| corr_value | output | DW+1 | Signed common-mode correction |
| hit_valid | output | 1 | Second-pass hit record valid |
| hit_strip | output | $clog2(NCH) | Strip number of the record |
| hit_left | output | DW | Sample of strip i−1 |
| hit_centre | output | DW | Sample of strip i |
| hit_right | output | DW | Sample of strip i+1 |
| hit_nb_ok | output | 2 | Neighbour exists: bit 0 left, bit 1 right |

## Verification
Some rules are checked by the assertions on every cycle:
- fast-pass results appear only after strip words;
- the correction pulse is a single cycle and its value is never positive;
- second-pass records appear only while a scan runs, with strictly increasing strip numbers;
- the neighbour mask is correct at both ends of the frame, and missing neighbours read as zero.

The bench scenarios are needed for the values themselves. These cover the exact threshold comparison at the equal-to boundary, the correction arithmetic, and hits that only the corrected pass finds. They also cover skipping a header that contains large values, ignoring a repeated frame start, ignoring a pedestal write during a scan, and back-to-back frames.

// File: rtl/hf_pkg.sv
package hf_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HDR  = 2'd1,
        RX_SAMP = 2'd2
    } rx_state_e;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_RUN  = 1'b1
    } scan_state_e;
endpackage

// File: rtl/hf_ped_mem.sv
module hf_ped_mem #(
    parameter int DW  = 12,
    parameter int NCH = 128,
    parameter int AW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [NCH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/hf_frame_buf.sv
module hf_frame_buf #(
    parameter int DW  = 12,
    parameter int NCH = 128,
    parameter int AW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rbank,
    input  logic [AW-1:0] raddr_c,
    input  logic [AW-1:0] raddr_l,
    input  logic [AW-1:0] raddr_r,
    output logic [DW-1:0] rdata_c,
    output logic [DW-1:0] rdata_l,
    output logic [DW-1:0] rdata_r
);
    logic [DW-1:0] bank0 [NCH];
    logic [DW-1:0] bank1 [NCH];

    always_ff @(posedge clk) begin
        if (we && !wbank) bank0[waddr] <= wdata;
        if (we &&  wbank) bank1[waddr] <= wdata;
    end

    assign rdata_c = rbank ? bank1[raddr_c] : bank0[raddr_c];
    assign rdata_l = rbank ? bank1[raddr_l] : bank0[raddr_l];
    assign rdata_r = rbank ? bank1[raddr_r] : bank0[raddr_r];
endmodule

// File: rtl/hf_cm_accum.sv
module hf_cm_accum #(
    parameter int DW  = 12,
    parameter int NCH = 128,
    parameter int AW  = $clog2(NCH),
    parameter int CW  = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 clr,
    input  logic [DW-1:0]        sample,
    input  logic [DW-1:0]        ped,
    output logic signed [CW-1:0] corr_next
);
    localparam int SW = DW + AW;

    logic [SW-1:0] sum_low;
    logic [SW-1:0] sum_ped;
    logic [SW-1:0] low_next;
    logic [SW-1:0] ped_next;
    logic [DW-1:0] lower;

    always_comb begin
        lower    = (sample < ped) ? sample : ped;
        low_next = (clr ? '0 : sum_low) + {{AW{1'b0}}, lower};
        ped_next = (clr ? '0 : sum_ped) + {{AW{1'b0}}, ped};
        corr_next = $signed({1'b0, low_next[SW-1:AW]})
                  - $signed({1'b0, ped_next[SW-1:AW]});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_low <= '0;
            sum_ped <= '0;
        end else if (en) begin
            sum_low <= low_next;
            sum_ped <= ped_next;
        end
    end
endmodule

// File: rtl/strip_hit_finder.sv
module strip_hit_finder #(
    parameter int DW  = 12,
    parameter int NCH = 128,
    parameter int HDR = 12,
    localparam int AW = $clog2(NCH),
    localparam int CW = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_start,
    input  logic [DW-1:0]        adc_data,
    input  logic [DW-1:0]        thr_level,
    input  logic                 ped_we,
    input  logic [AW-1:0]        ped_addr,
    input  logic [DW-1:0]        ped_wdata,
    output logic                 trig_valid,
    output logic                 trig_hit,
    output logic                 corr_valid,
    output logic signed [CW-1:0] corr_value,
    output logic                 hit_valid,
    output logic [AW-1:0]        hit_strip,
    output logic [DW-1:0]        hit_left,
    output logic [DW-1:0]        hit_centre,
    output logic [DW-1:0]        hit_right,
    output logic [1:0]           hit_nb_ok
);
    import hf_pkg::*;

    localparam logic [AW-1:0] HDR_LAST = AW'(HDR - 1);
    localparam logic [AW-1:0] CH_LAST  = AW'(NCH - 1);
    localparam int            XW       = DW + 4;

    rx_state_e   rx_state, rx_next;
    scan_state_e sc_state, sc_next;
    logic [AW-1:0] rx_cnt;
    logic [AW-1:0] sc_idx;
    logic [DW-1:0] thr_q;
    logic [DW-1:0] sc_thr;
    logic signed [CW-1:0] sc_corr;
    logic          wbank, rbank;

    logic          last_smp;
    logic          in_samp;
    logic [DW-1:0] ped_a, ped_b;
    logic [DW-1:0] buf_c, buf_l, buf_r;
    logic signed [CW-1:0] corr_next;
    logic          hit1, hit2;
    logic [DW:0]   lim1;
    logic signed [XW-1:0] lim2;

    assign in_samp  = (rx_state == RX_SAMP);
    assign last_smp = in_samp && (rx_cnt == CH_LAST);

    // Receiver state register and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_state <= RX_IDLE;
            rx_cnt   <= '0;
            thr_q    <= '0;
        end else begin
            rx_state <= rx_next;
            unique case (rx_state)
                RX_IDLE: if (frm_start) begin
                    rx_cnt <= AW'(1);
                    thr_q  <= thr_level;
                end
                RX_HDR:  rx_cnt <= (rx_cnt == HDR_LAST) ? '0 : rx_cnt + AW'(1);
                RX_SAMP: rx_cnt <= (rx_cnt == CH_LAST) ? '0 : rx_cnt + AW'(1);
                default: rx_cnt <= '0;
            endcase
        end
    end

    always_comb begin
        rx_next = rx_state;
        unique case (rx_state)
            RX_IDLE: if (frm_start)          rx_next = RX_HDR;
            RX_HDR:  if (rx_cnt == HDR_LAST) rx_next = RX_SAMP;
            RX_SAMP: if (rx_cnt == CH_LAST)  rx_next = RX_IDLE;
            default:                         rx_next = RX_IDLE;
        endcase
    end

    // Scan state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_state <= SC_IDLE;
            sc_idx   <= '0;
            sc_corr  <= '0;
            sc_thr   <= '0;
            wbank    <= 1'b0;
            rbank    <= 1'b0;
        end else begin
            sc_state <= sc_next;
            if (last_smp) begin
                sc_idx  <= '0;
                sc_corr <= corr_next;
                sc_thr  <= thr_q;
                rbank   <= wbank;
                wbank   <= ~wbank;
            end else if (sc_state == SC_RUN) begin
                sc_idx <= sc_idx + AW'(1);
            end
        end
    end

    always_comb begin
        sc_next = sc_state;
        unique case (sc_state)
            SC_IDLE: if (last_smp) sc_next = SC_RUN;
            SC_RUN:  if (sc_idx == CH_LAST && !last_smp) sc_next = SC_IDLE;
            default: sc_next = SC_IDLE;
        endcase
    end

    hf_ped_mem #(.DW(DW), .NCH(NCH), .AW(AW)) u_ped (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ped_we && rx_state == RX_IDLE && sc_state == SC_IDLE),
        .waddr   (ped_addr),
        .wdata   (ped_wdata),
        .raddr_a (rx_cnt),
        .rdata_a (ped_a),
        .raddr_b (sc_idx),
        .rdata_b (ped_b)
    );

    hf_frame_buf #(.DW(DW), .NCH(NCH), .AW(AW)) u_buf (
        .clk     (clk),
        .we      (in_samp),
        .wbank   (wbank),
        .waddr   (rx_cnt),
        .wdata   (adc_data),
        .rbank   (rbank),
        .raddr_c (sc_idx),
        .raddr_l (sc_idx - AW'(1)),
        .raddr_r (sc_idx + AW'(1)),
        .rdata_c (buf_c),
        .rdata_l (buf_l),
        .rdata_r (buf_r)
    );

    hf_cm_accum #(.DW(DW), .NCH(NCH), .AW(AW), .CW(CW)) u_cm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (in_samp),
        .clr       (rx_cnt == '0),
        .sample    (adc_data),
        .ped       (ped_a),
        .corr_next (corr_next)
    );

    // Comparisons of both passes
    always_comb begin
        lim1 = {1'b0, ped_a} + {1'b0, thr_q};
        hit1 = {1'b0, adc_data} > lim1;
        lim2 = $signed({4'b0, ped_b})
             + $signed({{(XW-CW){sc_corr[CW-1]}}, sc_corr})
             + $signed({4'b0, sc_thr});
        hit2 = $signed({4'b0, buf_c}) > lim2;
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_valid <= 1'b0;
            trig_hit   <= 1'b0;
            corr_valid <= 1'b0;
            corr_value <= '0;
            hit_valid  <= 1'b0;
            hit_strip  <= '0;
            hit_left   <= '0;
            hit_centre <= '0;
            hit_right  <= '0;
            hit_nb_ok  <= '0;
        end else begin
            trig_valid <= in_samp;
            trig_hit   <= in_samp && hit1;
            corr_valid <= last_smp;
            if (last_smp) corr_value <= corr_next;
            hit_valid  <= (sc_state == SC_RUN) && hit2;
            if (sc_state == SC_RUN && hit2) begin
                hit_strip    <= sc_idx;
                hit_centre   <= buf_c;
                hit_nb_ok[0] <= (sc_idx != '0);
                hit_nb_ok[1] <= (sc_idx != CH_LAST);
                hit_left     <= (sc_idx != '0)      ? buf_l : '0;
                hit_right    <= (sc_idx != CH_LAST) ? buf_r : '0;
            end
        end
    end
endmodule

// File: rtl/strip_hit_finder_chk.sv
module strip_hit_finder_chk #(
    parameter int DW  = 12,
    parameter int NCH = 128,
    localparam int AW = $clog2(NCH),
    localparam int CW = DW + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_samp,
    input logic                 scan_run,
    input logic                 trig_valid,
    input logic                 corr_valid,
    input logic signed [CW-1:0] corr_value,
    input logic                 hit_valid,
    input logic [AW-1:0]        hit_strip,
    input logic [DW-1:0]        hit_left,
    input logic [DW-1:0]        hit_right,
    input logic [1:0]           hit_nb_ok
);
    a_r2_trig_after_strip: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> $past(in_samp));

    a_r4_corr_not_positive: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> (corr_value <= 0));

    a_r4_corr_single: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |=> !corr_valid);

    a_r6_hit_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(scan_run));

    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && $past(hit_valid)) |-> (hit_strip > $past(hit_strip)));

    a_r7_edge_mask: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_nb_ok[0] == (hit_strip != '0)
                    && hit_nb_ok[1] == (hit_strip != AW'(NCH - 1))));

    a_r7_left_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_nb_ok[0]) |-> (hit_left == '0));

    a_r7_right_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_nb_ok[1]) |-> (hit_right == '0));
endmodule

bind strip_hit_finder strip_hit_finder_chk #(.DW(DW), .NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_samp    (rx_state == hf_pkg::RX_SAMP),
    .scan_run   (sc_state == hf_pkg::SC_RUN),
    .trig_valid (trig_valid),
    .corr_valid (corr_valid),
    .corr_value (corr_value),
    .hit_valid  (hit_valid),
    .hit_strip  (hit_strip),
    .hit_left   (hit_left),
    .hit_right  (hit_right),
    .hit_nb_ok  (hit_nb_ok)
);

// File: tb/strip_hit_finder_test.sv
module strip_hit_finder_test;
    localparam int DW  = 12;
    localparam int NCH = 128;
    localparam int HDR = 12;
    localparam int AW  = $clog2(NCH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_start = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic [DW-1:0] thr_level = '0;
    logic ped_we = 1'b0;
    logic [AW-1:0] ped_addr = '0;
    logic [DW-1:0] ped_wdata = '0;
    logic trig_valid, trig_hit, corr_valid, hit_valid;
    logic signed [DW:0] corr_value;
    logic [AW-1:0] hit_strip;
    logic [DW-1:0] hit_left, hit_centre, hit_right;
    logic [1:0] hit_nb_ok;

    strip_hit_finder #(.DW(DW), .NCH(NCH), .HDR(HDR)) uut (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .adc_data(adc_data),
        .thr_level(thr_level), .ped_we(ped_we), .ped_addr(ped_addr),
        .ped_wdata(ped_wdata), .trig_valid(trig_valid), .trig_hit(trig_hit),
        .corr_valid(corr_valid), .corr_value(corr_value), .hit_valid(hit_valid),
        .hit_strip(hit_strip), .hit_left(hit_left), .hit_centre(hit_centre),
        .hit_right(hit_right), .hit_nb_ok(hit_nb_ok)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int mped[NCH];
    int smp[NCH];
    string ftag = "R1";

    bit exp_trig [int];
    int exp_corr [int];
    int eh_strip [int];
    int eh_l [int];
    int eh_c [int];
    int eh_r [int];
    int eh_m [int];

    task automatic fail(string req, string what, int act, int exp);
        nerr++;
        $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    endtask

    // Compare outputs against the reference queues for the current cycle
    task automatic check_now();
        if (exp_trig.exists(cyc)) begin
            nchk++;
            if (!trig_valid) fail({ftag, "/R2"}, "trig_valid", 0, 1);
            else if (trig_hit !== exp_trig[cyc]) fail({ftag, "/R3"}, "trig_hit", int'(trig_hit), int'(exp_trig[cyc]));
            exp_trig.delete(cyc);
        end else if (trig_valid) begin
            nchk++;
            fail({ftag, "/R2"}, "unexpected trig_valid", 1, 0);
        end
        if (exp_corr.exists(cyc)) begin
            nchk++;
            if (!corr_valid) fail({ftag, "/R4"}, "corr_valid", 0, 1);
            else if (int'(corr_value) != exp_corr[cyc]) fail({ftag, "/R4"}, "corr_value", int'(corr_value), exp_corr[cyc]);
            exp_corr.delete(cyc);
        end else if (corr_valid) begin
            nchk++;
            fail({ftag, "/R4"}, "unexpected corr_valid", 1, 0);
        end
        if (eh_strip.exists(cyc)) begin
            nchk++;
            if (!hit_valid) fail({ftag, "/R5"}, "hit_valid missing for strip", 0, eh_strip[cyc]);
            else if (int'(hit_strip) != eh_strip[cyc]) fail({ftag, "/R6"}, "hit_strip", int'(hit_strip), eh_strip[cyc]);
            else if (int'(hit_centre) != eh_c[cyc]) fail({ftag, "/R7"}, "hit_centre", int'(hit_centre), eh_c[cyc]);
            else if (int'(hit_left) != eh_l[cyc]) fail({ftag, "/R7"}, "hit_left", int'(hit_left), eh_l[cyc]);
            else if (int'(hit_right) != eh_r[cyc]) fail({ftag, "/R7"}, "hit_right", int'(hit_right), eh_r[cyc]);
            else if (int'(hit_nb_ok) != eh_m[cyc]) fail({ftag, "/R7"}, "hit_nb_ok", int'(hit_nb_ok), eh_m[cyc]);
            eh_strip.delete(cyc);
        end else if (hit_valid) begin
            nchk++;
            fail({ftag, "/R5"}, "unexpected hit for strip", int'(hit_strip), -1);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        check_now();
        frm_start = 1'b0;
        ped_we    = 1'b0;
    endtask

    task automatic ped_write(int a, int d, bit applies);
        tick();
        ped_we    = 1'b1;
        ped_addr  = AW'(a);
        ped_wdata = DW'(d);
        if (applies) mped[a] = d;
    endtask

    // Drive a frame from smp[] and record expected outputs
    task automatic drive_frame(string tag, int thr, int extra_start);
        int sum_low = 0;
        int sum_ped = 0;
        int last;
        int corr;
        tick();
        ftag = tag;
        frm_start = 1'b1;
        thr_level = DW'(thr);
        adc_data  = '1;
        for (int h = 1; h < HDR; h++) begin
            tick();
            adc_data = '1;
            thr_level = '0;
            if (h == extra_start) frm_start = 1'b1;
        end
        for (int i = 0; i < NCH; i++) begin
            tick();
            adc_data = DW'(smp[i]);
            exp_trig[cyc + 1] = (smp[i] > mped[i] + thr);
            sum_low += (smp[i] < mped[i]) ? smp[i] : mped[i];
            sum_ped += mped[i];
        end
        last = cyc;
        corr = sum_low / NCH - sum_ped / NCH;
        exp_corr[last + 1] = corr;
        for (int i = 0; i < NCH; i++) begin
            if (smp[i] > mped[i] + corr + thr) begin
                eh_strip[last + 2 + i] = i;
                eh_c[last + 2 + i] = smp[i];
                eh_l[last + 2 + i] = (i > 0) ? smp[i - 1] : 0;
                eh_r[last + 2 + i] = (i < NCH - 1) ? smp[i + 1] : 0;
                eh_m[last + 2 + i] = ((i < NCH - 1) ? 2 : 0) + ((i > 0) ? 1 : 0);
            end
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) mped[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs quiet after reset
        tick();
        nchk++;
        if (trig_valid || corr_valid || hit_valid)
            fail("R1", "valids after reset", int'({trig_valid, corr_valid, hit_valid}), 0);

        // R1: pedestals read as zero; header of all ones must be skipped (R2)
        for (int i = 0; i < NCH; i++) smp[i] = (i * 37) % 300;
        drive_frame("R1", 100, 0);
        idle(NCH + 4);

        for (int i = 0; i < NCH; i++) ped_write(i, 200 + (i % 7) * 10, 1'b1);
        idle(2);

        // R3: exact-threshold boundary, hits at both ends
        for (int i = 0; i < NCH; i++) smp[i] = mped[i] - 5;
        smp[0]   = mped[0] + 300;
        smp[127] = mped[127] + 300;
        smp[10]  = mped[10] + 50;
        smp[11]  = mped[11] + 51;
        smp[64]  = mped[64] + 200;
        smp[65]  = mped[65] + 180;
        drive_frame("R3", 50, 0);

        // R9: back-to-back frame with baseline shift; R2: repeated start ignored
        for (int i = 0; i < NCH; i++) smp[i] = mped[i] - 60;
        smp[126] = mped[126] + 30;
        smp[127] = mped[127] + 100;
        smp[1]   = mped[1] + 5;
        drive_frame("R9", 50, 3);

        // R8: write during the scan is ignored
        ped_write(5, 4000, 1'b0);
        idle(NCH + 4);

        for (int i = 0; i < NCH; i++) smp[i] = mped[i] + 10;
        smp[5] = mped[5] + 30;
        smp[0] = mped[0] + 25;
        drive_frame("R8", 20, 0);
        idle(NCH + 6);

        nchk++;
        if (exp_trig.size() != 0 || eh_strip.size() != 0 || exp_corr.size() != 0)
            fail("R6", "pending expectations", exp_trig.size() + eh_strip.size(), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        nchk++;
        fail("R2", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule